// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Register Programming

This block merges up to 64 interrupt request lines into one interrupt output for a processor. Software programs it through a simple 32-bit register bus with one-cycle write strobes and one-cycle read strobes. Each line has a mask bit that is set and cleared through separate write-one-to-act registers. Each line also has its own configuration word that selects edge or level capture and gives it a priority level.

The controller keeps track of which lines are pending and eligible. Software reads a vector register to learn the number of the winning line, and the vector returns the line count (64) when no line qualifies. The read also takes the line into service. Lines at or below the priority of the line in service stay held off until software writes the end-of-interrupt register. Nothing reaches the output until a global enable bit is set. A write to the soft-reset register clears all programmed state.

The vector read marks one level as in service, and a later read of a higher-priority line replaces that level. A single end-of-interrupt write ends service completely.

Top module: `irq_hub`

## Requirements
- R1: A write to the enable-set word at byte offset 0x200 (lines 0–31) or 0x204 (lines 32–63) enables every line whose data bit is 1. Lines whose data bit is 0 keep their state. A read at either offset returns the current mask word, with bit k standing for line k or line 32+k.
- R2: A write to the enable-clear word at 0x208 (lines 0–31) or 0x20C (lines 32–63) disables every line whose data bit is 1 and leaves the others unchanged. A disabled line is never selected. A read at these offsets returns the same mask word as R1.
- R3: The configuration word of line n sits at byte offset 8·n. Bit 16 selects edge capture (1) or level capture (0), and bits 3:0 hold the priority. Reads at that offset return the same fields, with all other bits zero.
- R4: A level-configured line is pending exactly while its input is high.
- R5: An edge-configured line latches pending on a 0→1 input transition. The latch stays set after the input falls, and it is cleared when a vector read selects that line.
- R6: Among enabled, pending, eligible lines, the highest priority value wins, and a tie goes to the lowest line number.
- R7: A read of the vector register at 0x210 returns the winning line number. It returns 64 when no line qualifies.
- R8: A vector read that finds a winner puts that priority in service. While a line is in service, only lines of strictly higher priority qualify. Any write to 0x214 ends service.
- R9: The interrupt output stays low while the global enable (bit 0 at 0x218, readable there) is 0.
- R10: The interrupt output is registered. It is high in the cycle after a cycle in which the global enable was set and some line qualified.
- R11: A write to 0x21C with bit 0 set clears the masks, configurations, edge latches, service state, global enable and interrupt output on the next clock.
- R12: After power-on reset, all masks, configurations and the global enable read as 0, the vector reads 64 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| src_in | input | NSRC | Request lines, synchronous to clk |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 10 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after bus_re |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume that the request lines are already synchronous to the clock. They also assume that a write strobe and a read strobe never occur in the same cycle, since the bus holds at most one access per cycle. The stimulus changes inputs only on the falling edge. It issues each access as a single-cycle strobe and never raises both strobes together. It keeps line numbers and priorities inside their programmed widths, so the edge-capture and selection checks always relate well-formed configuration state.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int BUS_AW   = 10;
  localparam int EDGE_BIT = 16;

  localparam logic [BUS_AW-1:0] A_ENA_LO = 10'h200;
  localparam logic [BUS_AW-1:0] A_ENA_HI = 10'h204;
  localparam logic [BUS_AW-1:0] A_DIS_LO = 10'h208;
  localparam logic [BUS_AW-1:0] A_DIS_HI = 10'h20C;
  localparam logic [BUS_AW-1:0] A_VEC    = 10'h210;
  localparam logic [BUS_AW-1:0] A_EOI    = 10'h214;
  localparam logic [BUS_AW-1:0] A_GEN    = 10'h218;
  localparam logic [BUS_AW-1:0] A_RST    = 10'h21C;
endpackage

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
  parameter int NSRC = 64,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [NSRC-1:0]  src_in,
  input  logic [NSRC-1:0]  edge_cfg,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  output logic [NSRC-1:0]  pend
);
  logic [NSRC-1:0] prev_q, prev_n, lat_q, lat_n, rise, take_mask;

  assign rise = src_in & ~prev_q;

  always_comb begin
    take_mask = '0;
    if (take) take_mask[take_idx] = 1'b1;
    lat_n  = (lat_q & ~take_mask) | (rise & edge_cfg);
    prev_n = src_in;
    if (clr_all) begin
      lat_n  = '0;
      prev_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= prev_n;
      lat_q  <= lat_n;
    end
  end

  assign pend = (edge_cfg & lat_q) | (~edge_cfg & src_in);

  // R5
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((lat_q & $past(rise & edge_cfg)) == $past(rise & edge_cfg)));
endmodule

// File: rtl/irq_hub_select.sv
module irq_hub_select #(
  parameter int NSRC = 64,
  parameter int PRIO_W = 4,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              pend,
  input  logic [NSRC-1:0]              en,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio,
  input  logic                         act,
  input  logic [PRIO_W-1:0]            lvl,
  output logic                         valid,
  output logic [IDX_W-1:0]             idx,
  output logic [PRIO_W-1:0]            sel_prio
);
  logic [NSRC-1:0] elig;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      elig[i] = pend[i] & en[i] & (!act || (prio[i] > lvl));
  end

  always_comb begin
    valid    = 1'b0;
    idx      = '0;
    sel_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!valid || prio[i] > sel_prio)) begin
        valid    = 1'b1;
        idx      = IDX_W'(i);
        sel_prio = prio[i];
      end
    end
  end

  // R6
  winner_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (pend[idx] && en[idx]));
  // R8
  winner_above_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && act) |-> (prio[idx] > lvl));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int NWORD = (NSRC + 31) / 32;

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [NSRC-1:0]             en_q, en_n, edge_q, edge_n;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q, prio_n;
  logic                        gen_q, gen_n, act_q, act_n, irq_q, irq_n;
  logic [PRIO_W-1:0]           lvl_q, lvl_n;
  logic [31:0]                 rdata_q, rdata_n;
  logic [NWORD*32-1:0]         en_pad;

  logic [1:0]       wr_ena, wr_dis;
  logic             wr_cfg, wr_gen, wr_eoi, soft_rst, rd_vec, take;
  logic [IDX_W-1:0] cfg_idx, sel_idx;
  logic             sel_valid;
  logic [PRIO_W-1:0] sel_prio;
  logic [NSRC-1:0]  pend;

  assign cfg_idx   = bus_addr[3 +: IDX_W];
  assign wr_cfg    = bus_we && !bus_addr[BUS_AW-1] && (bus_addr[2:0] == 3'b000)
                     && ({1'b0, cfg_idx} < (IDX_W+1)'(NSRC));
  assign wr_ena[0] = bus_we && (bus_addr == A_ENA_LO);
  assign wr_ena[1] = bus_we && (bus_addr == A_ENA_HI);
  assign wr_dis[0] = bus_we && (bus_addr == A_DIS_LO);
  assign wr_dis[1] = bus_we && (bus_addr == A_DIS_HI);
  assign wr_gen    = bus_we && (bus_addr == A_GEN);
  assign wr_eoi    = bus_we && (bus_addr == A_EOI);
  assign soft_rst  = bus_we && (bus_addr == A_RST) && bus_wdata[0];
  assign rd_vec    = bus_re && (bus_addr == A_VEC);
  assign take      = rd_vec && sel_valid;

  always_comb begin
    en_pad = '0;
    en_pad[NSRC-1:0] = en_q;
  end

  irq_hub_capture #(.NSRC(NSRC), .IDX_W(IDX_W)) cap_i (
    .clk(clk), .rst_n(rst_i_n), .clr_all(soft_rst), .src_in(src_in),
    .edge_cfg(edge_q), .take(take), .take_idx(sel_idx), .pend(pend));

  irq_hub_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) sel_i (
    .clk(clk), .rst_n(rst_i_n), .pend(pend), .en(en_q), .prio(prio_q),
    .act(act_q), .lvl(lvl_q), .valid(sel_valid), .idx(sel_idx),
    .sel_prio(sel_prio));

  // next state
  always_comb begin
    en_n   = en_q;
    edge_n = edge_q;
    prio_n = prio_q;
    gen_n  = gen_q;
    act_n  = act_q;
    lvl_n  = lvl_q;
    irq_n  = gen_q && sel_valid;
    for (int i = 0; i < NSRC; i++) begin
      if (wr_ena[i/32] && bus_wdata[i%32]) en_n[i] = 1'b1;
      if (wr_dis[i/32] && bus_wdata[i%32]) en_n[i] = 1'b0;
    end
    if (wr_cfg) begin
      edge_n[cfg_idx] = bus_wdata[EDGE_BIT];
      prio_n[cfg_idx] = bus_wdata[PRIO_W-1:0];
    end
    if (wr_gen) gen_n = bus_wdata[0];
    if (wr_eoi) begin
      act_n = 1'b0;
    end else if (take) begin
      act_n = 1'b1;
      lvl_n = sel_prio;
    end
    if (soft_rst) begin
      en_n   = '0;
      edge_n = '0;
      prio_n = '0;
      gen_n  = 1'b0;
      act_n  = 1'b0;
      lvl_n  = '0;
      irq_n  = 1'b0;
    end
  end

  // read data
  always_comb begin
    rdata_n = 32'h0;
    if (!bus_addr[BUS_AW-1]) begin
      if (bus_addr[2:0] == 3'b000 && ({1'b0, cfg_idx} < (IDX_W+1)'(NSRC))) begin
        rdata_n[EDGE_BIT]     = edge_q[cfg_idx];
        rdata_n[PRIO_W-1:0]   = prio_q[cfg_idx];
      end
    end else begin
      case (bus_addr)
        A_ENA_LO, A_DIS_LO: rdata_n = en_pad[31:0];
        A_ENA_HI, A_DIS_HI: rdata_n = (NWORD > 1) ? en_pad[NWORD*32-1 -: 32] : 32'h0;
        A_VEC:              rdata_n = sel_valid ? 32'(sel_idx) : 32'(NSRC);
        A_GEN:              rdata_n = {31'h0, gen_q};
        default:            rdata_n = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q    <= '0;
      edge_q  <= '0;
      prio_q  <= '0;
      gen_q   <= 1'b0;
      act_q   <= 1'b0;
      lvl_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= 32'h0;
    end else begin
      en_q   <= en_n;
      edge_q <= edge_n;
      prio_q <= prio_n;
      gen_q  <= gen_n;
      act_q  <= act_n;
      lvl_q  <= lvl_n;
      irq_q  <= irq_n;
      if (bus_re) rdata_q <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  // R11
  soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    soft_rst |=> (en_q == '0 && !gen_q && !act_q && !irq_q));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq_out |-> $past(gen_q));
  // R1
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_ena[0] && !soft_rst) |=> (en_pad[31:0] == ($past(en_pad[31:0]) | $past(bus_wdata))));
  // R8
  eoi_end_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_eoi |=> !act_q);
endmodule

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
  localparam int N = 64;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  always #5 clk = ~clk;

  irq_hub #(.NSRC(N), .PRIO_W(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  int n_chk = 0, n_fail = 0;
  string tag = "R12";
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_en[N], m_edge[N], m_lat[N], m_prev[N];
  int m_prio[N];
  bit m_gen, m_act, exp_irq, rd_chk;
  int m_lvl, exp_rd;

  function automatic void m_pick(output bit v, output int w);
    v = 0; w = 0;
    for (int i = 0; i < N; i++) begin
      bit p;
      p = m_edge[i] ? m_lat[i] : src_in[i];
      if (p && m_en[i] && (!m_act || m_prio[i] > m_lvl) && (!v || m_prio[i] > m_prio[w])) begin
        v = 1; w = i;
      end
    end
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_edge[i] = 0; m_lat[i] = 0; m_prev[i] = 0; m_prio[i] = 0;
    end
    m_gen = 0; m_act = 0; m_lvl = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); exp_irq = 0; rd_chk = 0;
    end else begin
      bit v, nirq; int w; int a;
      m_pick(v, w);
      nirq = m_gen && v;
      a = int'(bus_addr);
      if (bus_re) begin
        rd_chk = 1;
        exp_rd = 0;
        if (a < 'h200 && a % 8 == 0) exp_rd = (m_edge[a/8] ? 32'h10000 : 0) | m_prio[a/8];
        else if (a == 'h200 || a == 'h208) for (int i = 0; i < 32; i++) exp_rd |= int'(m_en[i]) << i;
        else if (a == 'h204 || a == 'h20C) for (int i = 0; i < 32; i++) exp_rd |= int'(m_en[32+i]) << i;
        else if (a == 'h210) exp_rd = v ? w : N;
        else if (a == 'h218) exp_rd = int'(m_gen);
      end
      for (int i = 0; i < N; i++) begin
        bit rise;
        rise = src_in[i] && !m_prev[i];
        m_lat[i] = (m_lat[i] && !(bus_re && a == 'h210 && v && i == w)) || (rise && m_edge[i]);
        m_prev[i] = src_in[i];
      end
      if (bus_we && a == 'h214) m_act = 0;
      else if (bus_re && a == 'h210 && v) begin m_act = 1; m_lvl = m_prio[w]; end
      if (bus_we) begin
        if (a < 'h200 && a % 8 == 0) begin
          m_edge[a/8] = bus_wdata[16]; m_prio[a/8] = int'(bus_wdata[3:0]);
        end
        for (int i = 0; i < 32; i++) begin
          if (a == 'h200 && bus_wdata[i]) m_en[i] = 1;
          if (a == 'h204 && bus_wdata[i]) m_en[32+i] = 1;
          if (a == 'h208 && bus_wdata[i]) m_en[i] = 0;
          if (a == 'h20C && bus_wdata[i]) m_en[32+i] = 0;
        end
        if (a == 'h218) m_gen = bus_wdata[0];
        if (a == 'h21C && bus_wdata[0]) begin m_clear(); nirq = 0; end
      end
      exp_irq = nirq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(irq_out == exp_irq, tag, int'(irq_out), int'(exp_irq));
      if (rd_chk) begin
        check(bus_rdata == exp_rd, tag, int'(bus_rdata), exp_rd);
        rd_chk = 0;
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1; idle(4);
    // R12 reset state, R7 empty vector
    tag = "R12"; rd(10'h210, v); check(v == 64, "R7", int'(v), 64);
    rd(10'h200, v); check(v == 0, "R12", int'(v), 0);
    check(irq_out == 0, "R12", int'(irq_out), 0);
    // R1 enable set, zero bits no effect
    tag = "R1";
    wr(10'h200, 32'h88); wr(10'h200, 32'h0); rd(10'h200, v); check(v == 32'h88, "R1", int'(v), 'h88);
    wr(10'h204, 32'h101); rd(10'h204, v); check(v == 32'h101, "R1", int'(v), 'h101);
    // R2 disable
    tag = "R2";
    wr(10'h20C, 32'h1); wr(10'h208, 32'h0); rd(10'h20C, v); check(v == 32'h100, "R2", int'(v), 'h100);
    rd(10'h208, v); check(v == 32'h88, "R2", int'(v), 'h88);
    // R3 configuration words
    tag = "R3";
    wr(10'h018, 32'h5); wr(10'h038, 32'h2); wr(10'h140, 32'h10005);
    rd(10'h140, v); check(v == 32'h10005, "R3", int'(v), 'h10005);
    // R9 gate closed
    tag = "R9"; src_in[7] = 1; idle(3); check(irq_out == 0, "R9", int'(irq_out), 0);
    // R10 registered output
    tag = "R10"; wr(10'h218, 32'h1); check(irq_out == 0, "R10", int'(irq_out), 0);
    idle(1); check(irq_out == 1, "R10", int'(irq_out), 1);
    // R4 level line
    tag = "R4"; rd(10'h210, v); check(v == 7, "R4", int'(v), 7);
    // R6 higher priority preempts
    tag = "R6"; src_in[3] = 1; idle(2); rd(10'h210, v); check(v == 3, "R6", int'(v), 3);
    wr(10'h214, 0);
    src_in[40] = 1; idle(1); src_in[40] = 0; idle(1);
    rd(10'h210, v); check(v == 3, "R6", int'(v), 3);
    // R8 hold-off at equal priority
    tag = "R8"; idle(2); check(irq_out == 0, "R8", int'(irq_out), 0);
    wr(10'h214, 0); idle(1); check(irq_out == 1, "R8", int'(irq_out), 1);
    // R5 edge latch held after input fell, cleared on vector read
    tag = "R5"; src_in[3] = 0; idle(1);
    rd(10'h210, v); check(v == 40, "R5", int'(v), 40);
    wr(10'h214, 0); rd(10'h210, v); check(v == 7, "R5", int'(v), 7);
    wr(10'h214, 0); src_in[7] = 0; idle(1);
    tag = "R7"; rd(10'h210, v); check(v == 64, "R7", int'(v), 64);
    // R2 disabled pending line is not selected
    tag = "R2"; src_in[7] = 1; wr(10'h208, 32'h80); idle(2);
    check(irq_out == 0, "R2", int'(irq_out), 0);
    rd(10'h210, v); check(v == 64, "R2", int'(v), 64);
    // R11 soft reset
    tag = "R11"; wr(10'h200, 32'h80); wr(10'h21C, 32'h1);
    rd(10'h200, v); check(v == 0, "R11", int'(v), 0);
    rd(10'h218, v); check(v == 0, "R11", int'(v), 0);
    rd(10'h140, v); check(v == 0, "R11", int'(v), 0);
    check(irq_out == 0, "R11", int'(irq_out), 0);
    // mixed traffic against the model (R6, R8, R5)
    tag = "R6"; wr(10'h218, 32'h1);
    for (int k = 0; k < 600; k++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: src_in = {$urandom, $urandom};
        1: wr(10'h200 + 10'(4 * $urandom_range(0, 1)), $urandom);
        2: wr(10'h208 + 10'(4 * $urandom_range(0, 1)), $urandom & $urandom);
        3: wr(10'(8 * $urandom_range(0, 63)), {15'h0, 1'($urandom), 12'h0, 4'($urandom)});
        4, 5: rd(10'h210, v);
        6: wr(10'h214, 0);
        default: idle(1);
      endcase
    end
    idle(2);
    finish_run();
  end
endmodule